// File: doc/BRIEF.md
# Text Screen Cursor Writer

This block turns a stream of character codes into writes to a text video memory of `COLS` columns by `ROWS` rows (80 by 60 by default). It keeps a cursor column and row. A printable code is stored at the cursor and the cursor moves on. At the end of a line the cursor wraps to the next line. When the cursor would move below the last row, the block scrolls the whole screen up by copying every cell one row higher, then blanks the bottom row. A small set of control codes clears the screen, returns the carriage and feeds a line. All other control codes are dropped.

The cell address is `ROW_STRIDE*row + col`. With the default stride of 96 this matches a memory laid out as 64 plus 32 cells per row. All accesses go through one memory port. The port has separate read and write strobes. A strobe is held until the memory reports ready. The producer sees `ready_o` and offers a character while it is high.

Top module: `text_cursor_writer`

## Requirements
- R1: Out of reset the cursor is at column 0, row 0. `ready_o` is high and neither memory strobe is active.
- R2: `ready_o` is high only while the block is idle. A character is taken on a clock edge where `ready_o` is high and `char_i[6:0]` is nonzero. Bit 7 of `char_i` has no effect.
- R3: A code of 0x00 is not a character. The block stays idle and makes no memory access.
- R4: A code from 0x20 to 0x7F is written as a 7-bit value to address `ROW_STRIDE*row + col`. The column then increments.
- R5: A character written in column `COLS-1` moves the cursor to column 0 of the next row.
- R6: Scrolling starts when a wrap or a line feed happens on row `ROWS-1`. Each cell of rows 1..`ROWS-1` is copied to the same column one row up. The bottom row is then filled with 0x20. The cursor stays on row `ROWS-1`.
- R7: Code 0x01 writes 0x20 to every cell (row-major order) and puts the cursor at column 0, row 0.
- R8: Code 0x0D sets the column to 0 and leaves the row unchanged.
- R9: Code 0x0A moves the cursor down one row and keeps the column. On the last row it scrolls instead, as in R6.
- R10: Any other code from 0x02 to 0x1F causes no memory access and leaves the cursor unchanged.
- R11: `mem_rd_o` and `mem_wr_o` are never high together. Once a strobe is raised, it and the address hold until a clock edge with `mem_ready_i` high. That edge completes the access, and read data is sampled on it.
- R12: The cursor stays inside the screen, so every address is below `ROW_STRIDE*ROWS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| char_i | input | 8 | Character code; bit 7 ignored, 0 means none |
| ready_o | output | 1 | Block idle and accepting a character |
| mem_addr_o | output | AW | Cell address, ROW_STRIDE*row + col |
| mem_wdata_o | output | 7 | Data to write |
| mem_rdata_i | input | 7 | Data read, sampled on the completing edge |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_ready_i | input | 1 | Completes the pending access |

## Verification
The hardest case is a scroll that starts from the last cell of the last row while the memory stalls at random. A skipped or doubled copy, or a bottom row left unblanked, only shows up as a misplaced character later on. The bench runs a small 4 by 3 screen with a row stride of 6. Its memory model has pseudo-random ready stalls. It fills the screen many times over with printable codes and line feeds, so scrolls start both from wraps and from line feeds. After every character it compares the whole memory, including the unused gap cells, against an arithmetic model of the screen.

// File: rtl/twr_pkg.sv
package twr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PUT, ST_SCR_RD, ST_SCR_WR, ST_FILL, ST_CLR
  } twr_state_e;

  typedef enum logic [1:0] {COL_HOLD, COL_ZERO, COL_INC} col_op_e;
  typedef enum logic [1:0] {ROW_HOLD, ROW_ZERO, ROW_INC, ROW_MAX} row_op_e;

  localparam logic [6:0] CH_CLS   = 7'h01;
  localparam logic [6:0] CH_LF    = 7'h0A;
  localparam logic [6:0] CH_CR    = 7'h0D;
  localparam logic [6:0] CH_SPACE = 7'h20;
endpackage

// File: rtl/twr_cursor.sv
module twr_cursor
  import twr_pkg::*;
#(
  parameter int COLS = 80,
  parameter int ROWS = 60,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  col_op_e       col_op_i,
  input  row_op_e       row_op_i,
  output logic [CW-1:0] col_o,
  output logic [RW-1:0] row_o
);
  logic [CW-1:0] col_q;
  logic [RW-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      row_q <= '0;
    end else begin
      unique case (col_op_i)
        COL_ZERO: col_q <= '0;
        COL_INC:  col_q <= col_q + 1'b1;
        default:  col_q <= col_q;
      endcase
      unique case (row_op_i)
        ROW_ZERO: row_q <= '0;
        ROW_INC:  row_q <= row_q + 1'b1;
        ROW_MAX:  row_q <= RW'(ROWS - 1);
        default:  row_q <= row_q;
      endcase
    end
  end

  assign col_o = col_q;
  assign row_o = row_q;

  // R12
  cursor_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(col_q) < COLS) && (int'(row_q) < ROWS));
  // R6
  no_row_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_op_i == ROW_INC) |-> (int'(row_q) != ROWS - 1));
  // R5
  no_col_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_op_i == COL_INC) |-> (int'(col_q) != COLS - 1));
endmodule

// File: rtl/twr_addr.sv
module twr_addr #(
  parameter int COLS       = 80,
  parameter int ROWS       = 60,
  parameter int ROW_STRIDE = 96,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS),
  localparam int AW = $clog2(ROW_STRIDE * ROWS)
) (
  input  logic [RW-1:0] row_i,
  input  logic [CW-1:0] col_i,
  output logic [AW-1:0] addr_o
);
  localparam int SHIFT = $clog2(ROW_STRIDE);

  logic [AW-1:0] row_base;

  generate
    if ((ROW_STRIDE & (ROW_STRIDE - 1)) == 0) begin : g_shift
      assign row_base = AW'(row_i) << SHIFT;
    end else begin : g_mul
      assign row_base = AW'(row_i) * AW'(ROW_STRIDE);
    end
  endgenerate

  assign addr_o = row_base + AW'(col_i);
endmodule

// File: rtl/twr_ctrl.sv
module twr_ctrl
  import twr_pkg::*;
#(
  parameter int COLS = 80,
  parameter int ROWS = 60,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [6:0]    code_i,
  input  logic [CW-1:0] col_i,
  input  logic [RW-1:0] row_i,
  input  logic          mem_ready_i,
  input  logic [6:0]    mem_rdata_i,
  output logic          ready_o,
  output col_op_e       col_op_o,
  output row_op_e       row_op_o,
  output logic [RW-1:0] acc_row_o,
  output logic [CW-1:0] acc_col_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [6:0]    mem_wdata_o
);
  twr_state_e    state_q, state_d;
  logic [6:0]    ch_q, buf_q;
  logic [RW-1:0] wrow_q;
  logic [CW-1:0] wcol_q;

  logic last_col, last_row, w_last_col, w_last_row, w_pen_row, walk_adv;

  assign last_col   = col_i == CW'(COLS - 1);
  assign last_row   = row_i == RW'(ROWS - 1);
  assign w_last_col = wcol_q == CW'(COLS - 1);
  assign w_last_row = wrow_q == RW'(ROWS - 1);
  assign w_pen_row  = wrow_q == RW'(ROWS - 2);

  always_comb begin
    state_d     = state_q;
    col_op_o    = COL_HOLD;
    row_op_o    = ROW_HOLD;
    acc_row_o   = row_i;
    acc_col_o   = col_i;
    mem_rd_o    = 1'b0;
    mem_wr_o    = 1'b0;
    mem_wdata_o = CH_SPACE;
    walk_adv    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (code_i == CH_CLS) begin
          col_op_o = COL_ZERO;
          row_op_o = ROW_ZERO;
          state_d  = ST_CLR;
        end else if (code_i == CH_CR) begin
          col_op_o = COL_ZERO;
        end else if (code_i == CH_LF) begin
          if (last_row) state_d = ST_SCR_RD;
          else          row_op_o = ROW_INC;
        end else if (code_i >= CH_SPACE) begin
          state_d = ST_PUT;
        end
      end
      ST_PUT: begin
        mem_wr_o    = 1'b1;
        mem_wdata_o = ch_q;
        if (mem_ready_i) begin
          if (last_col) begin
            col_op_o = COL_ZERO;
            if (last_row) state_d = ST_SCR_RD;
            else begin
              row_op_o = ROW_INC;
              state_d  = ST_IDLE;
            end
          end else begin
            col_op_o = COL_INC;
            state_d  = ST_IDLE;
          end
        end
      end
      ST_SCR_RD: begin
        mem_rd_o  = 1'b1;
        acc_row_o = wrow_q + 1'b1;
        acc_col_o = wcol_q;
        if (mem_ready_i) state_d = ST_SCR_WR;
      end
      ST_SCR_WR: begin
        mem_wr_o    = 1'b1;
        mem_wdata_o = buf_q;
        acc_row_o   = wrow_q;
        acc_col_o   = wcol_q;
        if (mem_ready_i) begin
          walk_adv = 1'b1;
          state_d  = (w_last_col && w_pen_row) ? ST_FILL : ST_SCR_RD;
        end
      end
      ST_FILL: begin
        mem_wr_o  = 1'b1;
        acc_row_o = wrow_q;
        acc_col_o = wcol_q;
        if (mem_ready_i) begin
          walk_adv = 1'b1;
          if (w_last_col) begin
            row_op_o = ROW_MAX;
            state_d  = ST_IDLE;
          end
        end
      end
      ST_CLR: begin
        mem_wr_o  = 1'b1;
        acc_row_o = wrow_q;
        acc_col_o = wcol_q;
        if (mem_ready_i) begin
          walk_adv = 1'b1;
          if (w_last_col && w_last_row) state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
      buf_q   <= '0;
      wrow_q  <= '0;
      wcol_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE) begin
        wrow_q <= '0;
        wcol_q <= '0;
        if (code_i != '0) ch_q <= code_i;
      end else if (walk_adv) begin
        if (w_last_col) begin
          wcol_q <= '0;
          wrow_q <= wrow_q + 1'b1;
        end else begin
          wcol_q <= wcol_q + 1'b1;
        end
      end
      if (state_q == ST_SCR_RD && mem_ready_i) buf_q <= mem_rdata_i;
    end
  end

  assign ready_o = state_q == ST_IDLE;

  // R11
  rd_wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));
  // R11
  strobe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mem_rd_o || mem_wr_o) && !mem_ready_i) |=>
      (mem_rd_o == $past(mem_rd_o) && mem_wr_o == $past(mem_wr_o)
       && $stable(acc_row_o) && $stable(acc_col_o)));
  // R2
  ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !(mem_rd_o || mem_wr_o));
  // R3
  null_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && code_i == '0) |=> ready_o);
endmodule

// File: rtl/text_cursor_writer.sv
module text_cursor_writer
  import twr_pkg::*;
#(
  parameter int COLS       = 80,
  parameter int ROWS       = 60,
  parameter int ROW_STRIDE = 96,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS),
  localparam int AW = $clog2(ROW_STRIDE * ROWS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    char_i,
  output logic          ready_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [6:0]    mem_wdata_o,
  input  logic [6:0]    mem_rdata_i,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  input  logic          mem_ready_i
);
  col_op_e       col_op;
  row_op_e       row_op;
  logic [CW-1:0] col, acc_col;
  logic [RW-1:0] row, acc_row;
  logic          unused_msb;

  assign unused_msb = char_i[7];

  twr_ctrl #(.COLS(COLS), .ROWS(ROWS)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .code_i      (char_i[6:0]),
    .col_i       (col),
    .row_i       (row),
    .mem_ready_i (mem_ready_i),
    .mem_rdata_i (mem_rdata_i),
    .ready_o     (ready_o),
    .col_op_o    (col_op),
    .row_op_o    (row_op),
    .acc_row_o   (acc_row),
    .acc_col_o   (acc_col),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .mem_wdata_o (mem_wdata_o)
  );

  twr_cursor #(.COLS(COLS), .ROWS(ROWS)) u_cursor (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .col_op_i (col_op),
    .row_op_i (row_op),
    .col_o    (col),
    .row_o    (row)
  );

  twr_addr #(.COLS(COLS), .ROWS(ROWS), .ROW_STRIDE(ROW_STRIDE)) u_addr (
    .row_i  (acc_row),
    .col_i  (acc_col),
    .addr_o (mem_addr_o)
  );

  // R12
  addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o) |-> (int'(mem_addr_o) < ROW_STRIDE * ROWS));
endmodule

// File: tb/tb_text_cursor_writer.sv
`timescale 1ns/1ps
module tb_text_cursor_writer;
  localparam int COLS = 4;
  localparam int ROWS = 3;
  localparam int S    = 6;
  localparam int N    = S * ROWS;
  localparam int AW   = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    char_in = 8'h00;
  logic          rdy;
  logic [AW-1:0] addr;
  logic [6:0]    wdata, rdata;
  logic          rd, wr;
  logic          mrdy = 1'b1;

  logic [6:0] mem [32];
  logic [6:0] exp_m [32];
  int brow, bcol;
  int checks = 0, errors = 0, excl_bad = 0;
  logic [7:0] lfsr = 8'hA5;
  bit done = 0;

  always #10 clk = ~clk;

  text_cursor_writer #(.COLS(COLS), .ROWS(ROWS), .ROW_STRIDE(S)) dut (
    .clk_i(clk), .rst_ni(rst_n), .char_i(char_in), .ready_o(rdy),
    .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_rdata_i(rdata),
    .mem_rd_o(rd), .mem_wr_o(wr), .mem_ready_i(mrdy)
  );

  assign rdata = mem[addr];
  always @(posedge clk) if (wr && mrdy) mem[addr] <= wdata;

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mrdy <= lfsr[0] | lfsr[3];
    if (rd && wr) excl_bad++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic scroll_model();
    for (int r = 0; r < ROWS - 1; r++)
      for (int c = 0; c < COLS; c++) exp_m[r*S+c] = exp_m[(r+1)*S+c];
    for (int c = 0; c < COLS; c++) exp_m[(ROWS-1)*S+c] = 7'h20;
  endtask

  task automatic model(input logic [7:0] ch);
    logic [6:0] c7 = ch[6:0];
    if (c7 == 7'h00) return;
    if (c7 == 7'h01) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++) exp_m[r*S+c] = 7'h20;
      brow = 0; bcol = 0;
    end else if (c7 == 7'h0D) bcol = 0;
    else if (c7 == 7'h0A) begin
      if (brow == ROWS - 1) scroll_model(); else brow++;
    end else if (c7 >= 7'h20) begin
      exp_m[brow*S+bcol] = c7;
      if (bcol == COLS - 1) begin
        bcol = 0;
        if (brow == ROWS - 1) scroll_model(); else brow++;
      end else bcol++;
    end
  endtask

  task automatic wait_ready();
    int n = 0;
    while (!rdy && n < 5000) begin @(negedge clk); n++; end
    if (!rdy) check(0, "watchdog ready", 0, 1);
  endtask

  task automatic compare(input string tag);
    int bad = -1;
    for (int i = 0; i < N; i++) if (mem[i] !== exp_m[i] && bad < 0) bad = i;
    if (bad < 0) check(1, tag, 0, 0);
    else check(0, $sformatf("%s cell %0d", tag, bad), mem[bad], exp_m[bad]);
  endtask

  task automatic send(input logic [7:0] ch, input string tag);
    wait_ready();
    char_in = ch;
    @(negedge clk);
    char_in = 8'h00;
    wait_ready();
    model(ch);
    compare(tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      mem[i] = 7'((i * 5 + 3) | 1);
      exp_m[i] = mem[i];
    end
    brow = 0; bcol = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rdy == 1'b1, "R1 ready", rdy, 1);
    check(!rd && !wr, "R1 strobes", {rd, wr}, 0);
    send(8'h5A, "R1 R4 home write");

    // R2: ready drops while a character is processed
    wait_ready();
    char_in = 8'h51;
    @(negedge clk);
    char_in = 8'h00;
    check(rdy == 1'b0, "R2 busy", rdy, 0);
    wait_ready();
    model(8'h51);
    compare("R2 R4 second char");

    send(8'h01, "R7 clear");
    // R4 R5 R6: fill screen and wrap past the last cell; odd chars carry bit 7 (R2)
    for (int i = 0; i < 14; i++)
      send(8'(8'h41 + i + ((i % 2) ? 8'h80 : 8'h00)), "R4 R5 R6 R2 fill");
    send(8'h0D, "R8 cr");
    send(8'h78, "R8 after cr");
    send(8'h0A, "R9 R6 lf last row");
    send(8'h79, "R9 after lf");

    send(8'h01, "R7 clear again");
    send(8'h61, "R7 home");
    send(8'h0A, "R9 lf");
    send(8'h62, "R9 column kept");
    send(8'h0D, "R8 cr mid");
    send(8'h63, "R8 col zero");

    // R10: ignored control codes
    for (int k = 0; k < 3; k++) begin
      logic [7:0] cc = (k == 0) ? 8'h02 : (k == 1) ? 8'h1F : 8'h9B;
      wait_ready();
      char_in = cc;
      @(negedge clk);
      char_in = 8'h00;
      check(rdy && !rd && !wr, "R10 no access", {rdy, rd, wr}, 4);
      compare("R10 memory");
    end
    send(8'h64, "R10 cursor unchanged");

    // R3: null code held
    wait_ready();
    char_in = 8'h00;
    begin
      bit quiet = 1;
      repeat (8) begin @(negedge clk); if (!rdy || rd || wr) quiet = 0; end
      check(quiet, "R3 null idle", quiet, 1);
    end
    compare("R3 memory");

    // R6 sweep: printable codes with line feeds mixed in
    for (int i = 0; i < 60; i++) begin
      if (i % 7 == 3) send(8'h0A, "R6 R9 sweep lf");
      else send(8'(8'h20 + (i * 13) % 96), "R6 R4 sweep");
    end

    check(excl_bad == 0, "R11 exclusive strobes", excl_bad, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule